// File: doc/BRIEF.md
# LPC Memory Cycle Target

This block is the target side of a Low Pin Count bus for single-byte memory transactions. On each rising clock edge it samples the active-low frame strobe and the 4-bit multiplexed address/data bus. It recognises a valid start nibble and decodes the cycle type as a memory read or a memory write. It then assembles a 32-bit address from eight nibbles. It answers only when the address lies inside a window at the very top of the 4 GB space, whose size is set by a local-address-width parameter.

Behind the bus logic is a plain byte-wide memory port with an address, write data, a one-clock write strobe, a one-clock read strobe and read data. The read data is expected one clock after the read strobe.

For a read, the block drives a sync nibble, the data byte low nibble first, and a 1111b turnaround nibble. For a write, it drives the sync nibble and the turnaround nibble. In every other clock the bus output enable stays low. A new frame strobe in the middle of a cycle abandons that cycle.

Top module: `lpc_mem_target`

## Requirements
- R1: While reset is low (synchronous, active low), and on the clock after it, `lad_oe`, `mem_rd` and `mem_we` are 0. This holds even when reset arrives in the middle of a cycle.
- R2: A cycle starts only when the nibble sampled with `frame_n` low is 0000b. When `frame_n` is held low for several clocks, only the last nibble sampled low counts. Any other start value leaves the block silent.
- R3: The nibble after the start selects the cycle: bits [3:1] = 010b give a read and 011b give a write, and bit 0 is ignored. Any other value gives no strobe and no bus drive.
- R4: The next eight nibbles form a 32-bit address, most significant nibble first. `mem_addr` carries its low `LA_W` bits (`LA_W` = 18 by default).
- R5: The block responds only if address bits 31 down to `LA_W` are all ones. Otherwise no strobe is raised and the bus is never driven.
- R6: Read timing, counting clocks after the last address nibble is sampled. Clock 1 has `mem_rd` high for one clock. `mem_rdata` is captured at the end of clock 2. Clock 3 drives the sync value 0000b, clock 4 drives data bits [3:0], clock 5 drives bits [7:4], clock 6 drives 1111b, and clock 7 releases the bus.
- R7: Write timing. Two data nibbles follow the address, low nibble first. In the clock after the high nibble, `mem_we` is high for one clock with `mem_wdata` and `mem_addr` valid. Three clocks after the high nibble the block drives sync 0000b, four clocks after it drives 1111b, and five clocks after it releases the bus.
- R8: `frame_n` sampled low in any state restarts start detection. The abandoned cycle raises no strobe, and the bus is not driven in the next clock.
- R9: `lad_oe` is high only in the sync, read-data and target-turnaround clocks of R6 and R7, and in no other clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low cycle-start strobe |
| lad_in | input | 4 | Nibble sampled from the bus |
| lad_out | output | 4 | Nibble driven onto the bus |
| lad_oe | output | 1 | Bus output enable |
| mem_addr | output | LA_W | Local byte address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | One-clock write strobe |
| mem_rd | output | 1 | One-clock read strobe |
| mem_rdata | input | 8 | Read data, valid the clock after `mem_rd` |

## Verification
All timing is counted from the clock in which the last address nibble is sampled (for a read) or the high data nibble is sampled (for a write). A read raises its strobe 1 clock later, drives sync 3 clocks later and the data at 4 and 5 clocks. A write raises its strobe 1 clock after the high nibble and drives sync 3 clocks later. The bench drives and samples on the falling edge. At every falling edge it compares the enable, the driven nibble and both strobes with a per-clock expectation built from the cycle index within the transaction. That index counts the registers on the path, so a result arriving one clock early or late is caught at the exact clock it is due. Cases with no response are checked over the whole transaction length, so any stray drive or strobe is reported.

// File: rtl/lpc_tgt_pkg.sv
// Package: shared constants and state type for the LPC memory target.
// Assumes: one byte per cycle, memory reads and writes only.
package lpc_tgt_pkg;
    localparam int          ADDR_NIBS = 8;
    localparam int          CNT_W     = $clog2(ADDR_NIBS);
    localparam logic [3:0]  NIB_START = 4'b0000;
    localparam logic [3:0]  NIB_SYNC  = 4'b0000;
    localparam logic [3:0]  NIB_TAR   = 4'b1111;
    localparam logic [2:0]  CT_READ   = 3'b010;
    localparam logic [2:0]  CT_WRITE  = 3'b011;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CTYPE, ST_ADDR, ST_WD0, ST_WD1, ST_HTAR0, ST_HTAR1,
        ST_SYNC, ST_RD0, ST_RD1, ST_TTAR0, ST_TTAR1
    } lpc_st_e;
endpackage

// File: rtl/lpc_tgt_window.sv
// Module: top-of-memory window decode.
// Does: flags a hit when every address bit above the local range is one.
// Assumes: the caller passes only bits [31:LA_W] of the full address.
module lpc_tgt_window #(
    parameter int LA_W = 18,
    localparam int HI_W = 32 - LA_W
) (
    input  logic [HI_W-1:0] addr_hi,
    output logic            hit
);
    // Purpose: all-ones reduction of the upper address bits.
    always_comb hit = &addr_hi;
endmodule

// File: rtl/lpc_tgt_fsm.sv
// Module: cycle state machine, address assembly and memory-port strobes.
// Does: tracks start/type/address/data fields, raises the one-clock strobes,
//       and captures read data for the bus driver.
// Assumes: read data is valid one clock after mem_rd.
module lpc_tgt_fsm
    import lpc_tgt_pkg::*;
#(
    parameter int LA_W = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_n,
    input  logic [3:0]      lad_in,
    input  logic            win_hit,
    output logic [31:0]     full_addr,
    output lpc_st_e         st,
    output logic [7:0]      rbuf,
    output logic [LA_W-1:0] mem_addr,
    output logic [7:0]      mem_wdata,
    output logic            mem_we,
    output logic            mem_rd,
    input  logic [7:0]      mem_rdata
);
    logic [27:0]      ash;
    logic [CNT_W-1:0] cnt;
    logic             is_wr;
    logic             addr_last;

    // Purpose: address as it stands once the current nibble is appended.
    always_comb full_addr = {ash, lad_in};
    // Purpose: marks the clock in which the final address nibble is sampled.
    always_comb addr_last = (st == ST_ADDR) && (cnt == CNT_W'(ADDR_NIBS - 1));

    // Purpose: state sequencing, field capture and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            ash       <= '0;
            cnt       <= '0;
            is_wr     <= 1'b0;
            rbuf      <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_we    <= 1'b0;
            mem_rd    <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            mem_rd <= 1'b0;
            if (!frame_n) begin
                st <= (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: st <= ST_IDLE;
                    ST_CTYPE: begin
                        cnt <= '0;
                        if (lad_in[3:1] == CT_READ) begin
                            is_wr <= 1'b0;
                            st    <= ST_ADDR;
                        end else if (lad_in[3:1] == CT_WRITE) begin
                            is_wr <= 1'b1;
                            st    <= ST_ADDR;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    ST_ADDR: begin
                        ash <= full_addr[27:0];
                        cnt <= cnt + 1'b1;
                        if (addr_last) begin
                            if (win_hit) begin
                                mem_addr <= full_addr[LA_W-1:0];
                                if (is_wr) begin
                                    st <= ST_WD0;
                                end else begin
                                    st     <= ST_HTAR0;
                                    mem_rd <= 1'b1;
                                end
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_WD0: begin
                        mem_wdata[3:0] <= lad_in;
                        st             <= ST_WD1;
                    end
                    ST_WD1: begin
                        mem_wdata[7:4] <= lad_in;
                        mem_we         <= 1'b1;
                        st             <= ST_HTAR0;
                    end
                    ST_HTAR0: st <= ST_HTAR1;
                    ST_HTAR1: begin
                        if (!is_wr) rbuf <= mem_rdata;
                        st <= ST_SYNC;
                    end
                    ST_SYNC:  st <= is_wr ? ST_TTAR0 : ST_RD0;
                    ST_RD0:   st <= ST_RD1;
                    ST_RD1:   st <= ST_TTAR0;
                    ST_TTAR0: st <= ST_TTAR1;
                    ST_TTAR1: st <= ST_IDLE;
                    default:  st <= ST_IDLE;
                endcase
            end
        end
    end

    // R6: read strobe lasts exactly one clock
    p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    // R7: write strobe lasts exactly one clock
    p_we_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    // R6: read strobe only follows the address phase
    p_rd_after_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> $past(st) == ST_ADDR);
    // R7: write strobe coincides with the host turnaround after data
    p_we_after_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> st == ST_HTAR0);
    // R5: a window miss never yields a read strobe
    p_miss_no_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_last && frame_n && !win_hit) |=> !mem_rd);
    // R6: strobes never overlap
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));
endmodule

// File: rtl/lpc_tgt_lad_drv.sv
// Module: bus nibble driver.
// Does: selects sync, read data nibbles or turnaround value and the enable.
// Assumes: state is registered upstream; output is combinational from it.
module lpc_tgt_lad_drv
    import lpc_tgt_pkg::*;
(
    input  lpc_st_e    st,
    input  logic [7:0] rbuf,
    output logic [3:0] lad_out,
    output logic       lad_oe
);
    // Purpose: per-state drive value and enable.
    always_comb begin
        lad_out = NIB_TAR;
        lad_oe  = 1'b0;
        case (st)
            ST_SYNC:  begin lad_out = NIB_SYNC;  lad_oe = 1'b1; end
            ST_RD0:   begin lad_out = rbuf[3:0]; lad_oe = 1'b1; end
            ST_RD1:   begin lad_out = rbuf[7:4]; lad_oe = 1'b1; end
            ST_TTAR0: begin lad_out = NIB_TAR;   lad_oe = 1'b1; end
            default:  begin lad_out = NIB_TAR;   lad_oe = 1'b0; end
        endcase
    end
endmodule

// File: rtl/lpc_mem_target.sv
// Module: LPC memory cycle target, top level.
// Does: joins the state machine, window decode and bus driver.
// Assumes: LA_W below 32; single-byte memory cycles only.
module lpc_mem_target
    import lpc_tgt_pkg::*;
#(
    parameter int LA_W = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_n,
    input  logic [3:0]      lad_in,
    output logic [3:0]      lad_out,
    output logic            lad_oe,
    output logic [LA_W-1:0] mem_addr,
    output logic [7:0]      mem_wdata,
    output logic            mem_we,
    output logic            mem_rd,
    input  logic [7:0]      mem_rdata
);
    logic [31:0] full_addr;
    logic        win_hit;
    lpc_st_e     st;
    logic [7:0]  rbuf;

    lpc_tgt_window #(.LA_W(LA_W)) u_win (
        .addr_hi (full_addr[31:LA_W]),
        .hit     (win_hit)
    );

    lpc_tgt_fsm #(.LA_W(LA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .lad_in    (lad_in),
        .win_hit   (win_hit),
        .full_addr (full_addr),
        .st        (st),
        .rbuf      (rbuf),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata)
    );

    lpc_tgt_lad_drv u_drv (
        .st      (st),
        .rbuf    (rbuf),
        .lad_out (lad_out),
        .lad_oe  (lad_oe)
    );

    // R8: a sampled frame strobe leaves the bus released next clock
    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> !lad_oe);
    // R9: every driven stretch opens with the sync value
    p_oe_sync_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_oe) |-> lad_out == NIB_SYNC);
endmodule

// File: tb/lpc_mem_target_bench.sv
`timescale 1ns/1ps
module lpc_mem_target_bench;
    localparam int  LA_W = 18;
    localparam real HALF = 2.5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_n = 1'b1;
    logic [3:0]      lad_in = 4'hF;
    logic [3:0]      lad_out;
    logic            lad_oe;
    logic [LA_W-1:0] mem_addr;
    logic [7:0]      mem_wdata;
    logic            mem_we;
    logic            mem_rd;
    logic [7:0]      mem_rdata = 8'h00;

    int total = 0;
    int bad   = 0;
    int rd_cnt = 0;
    bit done  = 1'b0;

    always #(HALF) clk = ~clk;

    lpc_mem_target #(.LA_W(LA_W)) u_lpc_mem_target (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] model(input logic [LA_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // memory model: data valid the clock after the read strobe
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= model(mem_addr);
            rd_cnt    <= rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic fr, input logic [3:0] nib);
        frame_n = fr;
        lad_in  = nib;
        @(negedge clk);
    endtask

    // {start, cycle type, address, write data}
    localparam logic [47:0] VEC [9] = '{
        {4'h0, 4'h4, 32'hFFFC1234, 8'h00},
        {4'h0, 4'h6, 32'hFFFFFFFF, 8'hA7},
        {4'h0, 4'h5, 32'hFFFC0000, 8'h00},
        {4'h0, 4'h7, 32'hFFFE8421, 8'h5C},
        {4'h0, 4'h4, 32'hFFFBFFFF, 8'h00},
        {4'h0, 4'h6, 32'h7FFFFFFF, 8'h99},
        {4'h0, 4'h0, 32'hFFFC0010, 8'h00},
        {4'h0, 4'h2, 32'hFFFC0010, 8'h33},
        {4'h3, 4'h4, 32'hFFFD0000, 8'h00}
    };

    // Full transaction, 18 clocks; expectations per clock index from R2-R9.
    task automatic run_cycle(input logic [3:0] sn, input logic [3:0] ct,
                             input logic [31:0] ad, input logic [7:0] wd);
        bit is_rd = (ct[3:1] == 3'b010);
        bit is_wr = (ct[3:1] == 3'b011);
        bit in_win = ((ad >> LA_W) == ((32'h1 << (32 - LA_W)) - 1));
        bit hit = (sn == 4'h0) && (is_rd || is_wr) && in_win;
        logic [7:0] rd = model(ad[LA_W-1:0]);
        string miss = (sn != 4'h0) ? "R2" : (!(is_rd || is_wr)) ? "R3" : "R5";
        for (int c = 0; c < 18; c++) begin
            bit e_rd = hit && is_rd && (c == 10);
            bit e_we = hit && is_wr && (c == 12);
            bit e_oe = hit && (is_rd ? (c >= 12 && c <= 15) : (c == 14 || c == 15));
            logic [3:0] e_lad = 4'hF;
            if (hit && is_rd && c == 12) e_lad = 4'h0;
            if (hit && is_rd && c == 13) e_lad = rd[3:0];
            if (hit && is_rd && c == 14) e_lad = rd[7:4];
            if (hit && is_wr && c == 14) e_lad = 4'h0;
            chk(hit ? "R6 mem_rd" : miss, {31'd0, mem_rd}, {31'd0, e_rd});
            chk(hit ? "R7 mem_we" : miss, {31'd0, mem_we}, {31'd0, e_we});
            chk(hit ? "R9 lad_oe" : miss, {31'd0, lad_oe}, {31'd0, e_oe});
            if (e_oe) chk(is_rd ? "R6 lad_out" : "R7 lad_out", {28'd0, lad_out}, {28'd0, e_lad});
            if (e_rd || e_we) chk("R4 mem_addr", {{(32-LA_W){1'b0}}, mem_addr}, {{(32-LA_W){1'b0}}, ad[LA_W-1:0]});
            if (e_we) chk("R7 mem_wdata", {24'd0, mem_wdata}, {24'd0, wd});
            if (c == 0)      step(1'b0, sn);
            else if (c == 1) step(1'b1, ct);
            else if (c <= 9) step(1'b1, ad[4*(9-c) +: 4]);
            else if (c == 10 && is_wr) step(1'b1, wd[3:0]);
            else if (c == 11 && is_wr) step(1'b1, wd[7:4]);
            else step(1'b1, 4'hF);
        end
    endtask

    initial begin
        #(HALF * 2 * 100000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 lad_oe", {31'd0, lad_oe}, 32'd0);
        chk("R1 mem_rd", {31'd0, mem_rd}, 32'd0);
        chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 9; i++)
            run_cycle(VEC[i][47:44], VEC[i][43:40], VEC[i][39:8], VEC[i][7:0]);

        // R2: frame held two clocks, first nibble nonzero, last zero -> valid
        step(1'b0, 4'h7);
        run_cycle(4'h0, 4'h4, 32'hFFFC00AB, 8'h00);
        // R2: frame held two clocks, last nibble nonzero -> ignored
        step(1'b0, 4'h0);
        run_cycle(4'h9, 4'h4, 32'hFFFC00AB, 8'h00);

        // R8: abort in the address phase, restart at once
        snap = rd_cnt;
        step(1'b0, 4'h0);
        step(1'b1, 4'h4);
        for (int k = 0; k < 4; k++) step(1'b1, 4'hF);
        chk("R8 no strobe from aborted cycle", rd_cnt, snap);
        run_cycle(4'h0, 4'h4, 32'hFFFC5A5A, 8'h00);
        chk("R8 one strobe after restart", rd_cnt, snap + 1);

        // R1: reset in the sync clock of a read
        step(1'b0, 4'h0);
        step(1'b1, 4'h4);
        for (int k = 0; k < 8; k++) step(1'b1, 4'hF);
        step(1'b1, 4'hF);
        step(1'b1, 4'hF);
        chk("R9 sync before reset", {31'd0, lad_oe}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 lad_oe after mid-cycle reset", {31'd0, lad_oe}, 32'd0);
        rst_n = 1'b1;
        step(1'b1, 4'hF);
        chk("R1 stays idle after reset", {31'd0, lad_oe}, 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule